// File: doc/BRIEF.md
# DSP Execution Unit with Wide Accumulator

This block is the arithmetic core of a 16-bit signal-processing datapath. Each cycle it receives an opcode and two operands. It returns a 16-bit result in the same cycle. On the next clock edge it updates a four-bit status register and, for the multiply class, a 40-bit accumulator. The accumulator holds 8 guard bits above a signed 32-bit product, so long sums of products can run without intermediate overflow. A rounding operation converts the accumulator back into a saturated 16-bit word.

The block also evaluates branch conditions. A 4-bit condition select is tested against the registered status bits. The resulting taken signal is produced combinationally, so a compare followed by a conditional jump resolves in the jump's own cycle. Each opcode class writes only its own subset of the status bits, so a carry produced by an add survives later logic and multiply operations. The register file, the decoder and any pipeline staging live outside this block.

Top module: `dsp_exec_unit`

## Requirements
- R1: The opcode encodings are NOP=0, ADD=1, SUB=2, ABS=3, INC=4, DEC=5, AND=6, OR=7, XOR=8, NOT=9, LSL=10, LSR=11, MPL=12, MAC=13, CAC=14 and RND=15. ADD computes A+B, SUB computes A-B (as A + ~B + 1), INC computes A+1 and DEC computes A+0xFFFF. Each of these sets C to the carry out of bit 15, V to two's-complement overflow, Z to result==0 and N to result bit 15. The flags port is {C,Z,N,V}, with C at bit 3 and V at bit 0.
- R2: ABS returns the magnitude of operand A. For A=0x8000 it returns 0x7FFF and sets V; otherwise it clears V. It updates Z and N from the result and leaves C unchanged.
- R3: AND, OR, XOR and NOT (NOT inverts A) set Z and N from the result, clear V and leave C unchanged.
- R4: LSL shifts A left and LSR shifts A right with zero fill. Both use only B[3:0] as the distance and discard bits that leave the word. Their flags follow R3.
- R5: MPL loads the accumulator with the signed 16x16 product of A and B, sign-extended to 40 bits. It sets Z and N from the new accumulator value (N is accumulator bit 39), clears V and leaves C unchanged.
- R6: MAC adds the signed product to the accumulator with 40-bit wraparound. It sets V when that addition overflows in two's complement, sets Z and N from the new accumulator value and leaves C unchanged.
- R7: CAC clears the accumulator and sets Z=1, N=0 and V=0, leaving C unchanged.
- R8: RND adds 0x8000 to the accumulator and takes bits [39:16] as a signed value. It clamps that value to 0x8000..0x7FFF and returns it as the result. V is set exactly when clamping occurred, Z and N follow the result, and C and the accumulator are unchanged.
- R9: NOP leaves the flags and the accumulator unchanged. The result is 0 for NOP, MPL, MAC and CAC.
- R10: The condition codes are 1=LT (N), 2=LE (N or Z), 3=EQ (Z), 4=GE (not N), 5=GT (neither N nor Z) and 6=NE (not Z). Each is evaluated on the registered flags.
- R11: Codes 7 (jump), 8 (call) and 9 (return) always assert taken. Codes 0 and 10 to 15 never do.
- R12: The result and taken outputs are combinational in the current inputs and stored state. Flags and accumulator change only at the rising clock edge. Reset (rst_n low) clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Operation select (R1 encoding) |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand, or shift distance in bits [3:0] |
| cond_sel | input | 4 | Branch condition select |
| result | output | 16 | Result word of the current operation |
| flags | output | 4 | Registered status {C,Z,N,V} |
| taken | output | 1 | Branch condition met for cond_sel |

## Verification
The result and taken outputs depend only on the inputs of the current cycle and on stored state, so they are due in the same cycle. The bench drives each vector just after a falling edge and compares these two outputs a few nanoseconds later, before the next rising edge. Flag and accumulator effects are due one rising edge after the vector. Flags are therefore compared shortly after that edge. Accumulator contents are seen through RND results, taken in the cycles that follow. The behavioural reference model advances its own state at the same edge, so every comparison uses the state the design should hold at that point.

// File: rtl/exec_pkg.sv
package exec_pkg;

   typedef enum logic [3:0] {
      OP_NOP = 4'd0,  OP_ADD = 4'd1,  OP_SUB = 4'd2,  OP_ABS = 4'd3,
      OP_INC = 4'd4,  OP_DEC = 4'd5,  OP_AND = 4'd6,  OP_OR  = 4'd7,
      OP_XOR = 4'd8,  OP_NOT = 4'd9,  OP_LSL = 4'd10, OP_LSR = 4'd11,
      OP_MPL = 4'd12, OP_MAC = 4'd13, OP_CAC = 4'd14, OP_RND = 4'd15
   } exec_op_e;

   typedef enum logic [3:0] {
      CC_NEVER = 4'd0, CC_LT = 4'd1, CC_LE = 4'd2, CC_EQ = 4'd3,
      CC_GE    = 4'd4, CC_GT = 4'd5, CC_NE = 4'd6, CC_JMP = 4'd7,
      CC_CALL  = 4'd8, CC_RET = 4'd9
   } exec_cc_e;

   typedef struct packed {
      logic c;
      logic z;
      logic n;
      logic v;
   } exec_flags_t;

endpackage

// File: rtl/exec_alu.sv
module exec_alu
   import exec_pkg::*;
#(
   parameter int DW           = 16,
   parameter bit ARITH_RSHIFT = 1'b0
) (
   input  exec_op_e        op,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   output logic [DW-1:0]   res,
   output logic            c_out,
   output logic            v_out
);
   localparam int SHW = $clog2(DW);
   localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

   logic [DW-1:0]  addend;
   logic           cin;
   logic [DW:0]    sum;
   logic [SHW-1:0] sh;
   logic [DW-1:0]  lsh;
   logic [DW-1:0]  rsh;
   logic [DW-1:0]  mag;
   logic           add_ovf;

   // one adder serves all four add-type opcodes
   always_comb begin
      case (op)
         OP_ADD:  begin addend = b;       cin = 1'b0; end
         OP_SUB:  begin addend = ~b;      cin = 1'b1; end
         OP_INC:  begin addend = '0;      cin = 1'b1; end
         OP_DEC:  begin addend = '1;      cin = 1'b0; end
         default: begin addend = '0;      cin = 1'b0; end
      endcase
   end

   assign sum     = {1'b0, a} + {1'b0, addend} + {{DW{1'b0}}, cin};
   assign add_ovf = (a[DW-1] == addend[DW-1]) && (sum[DW-1] != a[DW-1]);

   assign sh  = b[SHW-1:0];
   assign lsh = a << sh;

   generate
      if (ARITH_RSHIFT) begin : g_rs_arith
         assign rsh = $unsigned($signed(a) >>> sh);
      end else begin : g_rs_logic
         assign rsh = a >> sh;
      end
   endgenerate

   assign mag = (a == NEG_MIN) ? POS_MAX : (a[DW-1] ? (~a + 1'b1) : a);

   always_comb begin
      res   = '0;
      c_out = 1'b0;
      v_out = 1'b0;
      case (op)
         OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
            res   = sum[DW-1:0];
            c_out = sum[DW];
            v_out = add_ovf;
         end
         OP_ABS: begin
            res   = mag;
            v_out = (a == NEG_MIN);
         end
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_NOT:  res = ~a;
         OP_LSL:  res = lsh;
         OP_LSR:  res = rsh;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/exec_mac.sv
module exec_mac
   import exec_pkg::*;
#(
   parameter int DW    = 16,
   parameter int GUARD = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  exec_op_e      op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] rnd_res,
   output logic          rnd_sat,
   output logic          acc_z,
   output logic          acc_n,
   output logic          acc_v
);
   localparam int PW = 2 * DW;
   localparam int AW = PW + GUARD;
   localparam int QW = AW + 1 - DW;
   localparam logic [AW:0]   HALF_LSB = (AW+1)'(1) << (DW - 1);
   localparam logic signed [QW-1:0] Q_MAX = {{(QW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [QW-1:0] Q_MIN = {{(QW-DW+1){1'b1}}, {(DW-1){1'b0}}};
   localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

   logic [AW-1:0]        acc_q;
   logic [AW-1:0]        acc_d;
   logic signed [PW-1:0] prod;
   logic [AW-1:0]        prod_x;
   logic [AW-1:0]        msum;
   logic                 mac_ovf;
   logic [AW:0]          rsum;
   logic signed [QW-1:0] q;
   logic                 q_hi;
   logic                 q_lo;

   assign prod    = $signed(a) * $signed(b);
   assign prod_x  = {{GUARD{prod[PW-1]}}, prod};
   assign msum    = acc_q + prod_x;
   assign mac_ovf = (acc_q[AW-1] == prod_x[AW-1]) && (msum[AW-1] != acc_q[AW-1]);

   always_comb begin
      case (op)
         OP_MPL:  acc_d = prod_x;
         OP_MAC:  acc_d = msum;
         OP_CAC:  acc_d = '0;
         default: acc_d = acc_q;
      endcase
   end

   assign acc_z = (acc_d == '0);
   assign acc_n = acc_d[AW-1];
   assign acc_v = (op == OP_MAC) && mac_ovf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

   // round at the half LSB, then clamp to the word range
   assign rsum    = {acc_q[AW-1], acc_q} + HALF_LSB;
   assign q       = $signed(rsum[AW:DW]);
   assign q_hi    = (q > Q_MAX);
   assign q_lo    = (q < Q_MIN);
   assign rnd_sat = q_hi || q_lo;
   assign rnd_res = q_hi ? POS_MAX : (q_lo ? NEG_MIN : q[DW-1:0]);

   // R7
   cac_clears_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CAC) |=> (acc_q == '0));

   // R8
   rnd_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_RND) |=> $stable(acc_q));

   // R9
   nop_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_NOP) |=> $stable(acc_q));

endmodule

// File: rtl/exec_cond.sv
module exec_cond
   import exec_pkg::*;
(
   input  exec_flags_t f,
   input  logic [3:0]  cc,
   output logic        taken
);
   always_comb begin
      case (cc)
         CC_LT:                   taken = f.n;
         CC_LE:                   taken = f.n | f.z;
         CC_EQ:                   taken = f.z;
         CC_GE:                   taken = ~f.n;
         CC_GT:                   taken = ~f.n & ~f.z;
         CC_NE:                   taken = ~f.z;
         CC_JMP, CC_CALL, CC_RET: taken = 1'b1;
         default:                 taken = 1'b0;
      endcase
   end
endmodule

// File: rtl/dsp_exec_unit.sv
module dsp_exec_unit
   import exec_pkg::*;
#(
   parameter int DW           = 16,
   parameter int GUARD        = 8,
   parameter bit ARITH_RSHIFT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    opcode,
   input  logic [DW-1:0] opnd_a,
   input  logic [DW-1:0] opnd_b,
   input  logic [3:0]    cond_sel,
   output logic [DW-1:0] result,
   output logic [3:0]    flags,
   output logic          taken
);
   generate
      if (DW < 4 || (DW & (DW - 1)) != 0) begin : g_bad_dw
         $error("dsp_exec_unit: DW must be a power of two of at least 4");
      end
      if (GUARD < 1) begin : g_bad_guard
         $error("dsp_exec_unit: GUARD must be at least 1");
      end
   endgenerate

   exec_op_e    op;
   exec_flags_t flags_q;
   exec_flags_t flags_d;
   logic [DW-1:0] alu_res;
   logic          alu_c;
   logic          alu_v;
   logic [DW-1:0] rnd_res;
   logic          rnd_sat;
   logic          acc_z;
   logic          acc_n;
   logic          acc_v;

   assign op = exec_op_e'(opcode);

   exec_alu #(.DW(DW), .ARITH_RSHIFT(ARITH_RSHIFT)) alu_i (
      .op(op), .a(opnd_a), .b(opnd_b),
      .res(alu_res), .c_out(alu_c), .v_out(alu_v)
   );

   exec_mac #(.DW(DW), .GUARD(GUARD)) mac_i (
      .clk(clk), .rst_n(rst_n), .op(op), .a(opnd_a), .b(opnd_b),
      .rnd_res(rnd_res), .rnd_sat(rnd_sat),
      .acc_z(acc_z), .acc_n(acc_n), .acc_v(acc_v)
   );

   exec_cond cond_i (
      .f(flags_q), .cc(cond_sel), .taken(taken)
   );

   always_comb begin
      case (op)
         OP_RND:                 result = rnd_res;
         OP_NOP, OP_MPL,
         OP_MAC, OP_CAC:         result = '0;
         default:                result = alu_res;
      endcase
   end

   // each opcode class owns its own subset of the status bits
   always_comb begin
      flags_d = flags_q;
      case (op)
         OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
            flags_d.c = alu_c;
            flags_d.z = (result == '0);
            flags_d.n = result[DW-1];
            flags_d.v = alu_v;
         end
         OP_ABS: begin
            flags_d.z = (result == '0);
            flags_d.n = result[DW-1];
            flags_d.v = alu_v;
         end
         OP_AND, OP_OR, OP_XOR, OP_NOT, OP_LSL, OP_LSR: begin
            flags_d.z = (result == '0);
            flags_d.n = result[DW-1];
            flags_d.v = 1'b0;
         end
         OP_MPL, OP_MAC, OP_CAC: begin
            flags_d.z = acc_z;
            flags_d.n = acc_n;
            flags_d.v = acc_v;
         end
         OP_RND: begin
            flags_d.z = (result == '0);
            flags_d.n = result[DW-1];
            flags_d.v = rnd_sat;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   assign flags = flags_q;

   // R2
   abs_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ABS) |-> !result[DW-1]);

   // R3
   logic_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_LSL, OP_LSR}) |=>
      (flags_q.c == $past(flags_q.c)));

   // R7
   cac_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CAC) |=> (flags_q.z && !flags_q.n && !flags_q.v));

   // R9
   nop_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_NOP) |=> $stable(flags_q));

   // R10
   eq_follows_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_sel == CC_EQ) |-> (taken == flags_q.z));

   // R11
   uncond_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_sel inside {CC_JMP, CC_CALL, CC_RET}) |-> taken);

endmodule

// File: tb/dsp_exec_unit_tb_top.sv
module dsp_exec_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  opcode;
   logic [15:0] opnd_a;
   logic [15:0] opnd_b;
   logic [3:0]  cond_sel;
   logic [15:0] result;
   logic [3:0]  flags;
   logic        taken;

   int vec_cnt = 0;
   int err_cnt = 0;
   bit done    = 1'b0;

   // reference state
   bit     mc, mz, mn, mv;
   longint macc;

   always #10 clk = ~clk;

   dsp_exec_unit dut_i (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .opnd_a(opnd_a),
      .opnd_b(opnd_b), .cond_sel(cond_sel), .result(result),
      .flags(flags), .taken(taken)
   );

   function automatic string tag_of(int op);
      case (op)
         0:              return "R9";
         1, 2, 4, 5:     return "R1";
         3:              return "R2";
         6, 7, 8, 9:     return "R3";
         10, 11:         return "R4";
         12:             return "R5";
         13:             return "R6";
         14:             return "R7";
         default:        return "R8";
      endcase
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      vec_cnt++;
      if (act != exp) begin
         err_cnt++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic bit ref_taken(int cc);
      case (cc)
         1: return mn;
         2: return mn | mz;
         3: return mz;
         4: return !mn;
         5: return !mn && !mz;
         6: return !mz;
         7, 8, 9: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic step(int op, int a, int b, int cc);
      int          au, bu, addend, er;
      logic [16:0] s;
      bit          nc, nz, nn, nv, et;
      longint      p, nacc, t;
      longint      lim;
      string       tg;
      au = a & 16'hFFFF;
      bu = b & 16'hFFFF;
      tg = tag_of(op);
      @(negedge clk);
      opcode   = 4'(op);
      opnd_a   = 16'(au);
      opnd_b   = 16'(bu);
      cond_sel = 4'(cc);
      #2;
      nc = mc; nz = mz; nn = mn; nv = mv; nacc = macc; er = 0;
      lim = longint'(1) <<< 39;
      p = longint'(shortint'(au)) * longint'(shortint'(bu));
      case (op)
         1, 2, 4, 5: begin
            case (op)
               1:       addend = bu;
               2:       addend = (~bu) & 16'hFFFF;
               4:       addend = 0;
               default: addend = 16'hFFFF;
            endcase
            s  = 17'(au + addend + ((op == 2 || op == 4) ? 1 : 0));
            er = int'(s[15:0]);
            nc = s[16];
            nv = (au[15] == addend[15]) && (er[15] != au[15]);
            nz = (er == 0);
            nn = er[15];
         end
         3: begin
            if (au == 16'h8000) begin er = 16'h7FFF; nv = 1'b1; end
            else begin er = au[15] ? ((-au) & 16'hFFFF) : au; nv = 1'b0; end
            nz = (er == 0); nn = er[15];
         end
         6, 7, 8, 9, 10, 11: begin
            case (op)
               6:       er = au & bu;
               7:       er = au | bu;
               8:       er = au ^ bu;
               9:       er = (~au) & 16'hFFFF;
               10:      er = (au << (bu & 15)) & 16'hFFFF;
               default: er = au >> (bu & 15);
            endcase
            nv = 1'b0; nz = (er == 0); nn = er[15];
         end
         12, 13, 14: begin
            nv = 1'b0;
            if (op == 12) nacc = p;
            else if (op == 14) nacc = 0;
            else begin
               nacc = macc + p;
               if (nacc >= lim) begin nacc = nacc - 2 * lim; nv = 1'b1; end
               else if (nacc < -lim) begin nacc = nacc + 2 * lim; nv = 1'b1; end
            end
            nz = (nacc == 0); nn = (nacc < 0);
         end
         15: begin
            t = (macc + 32768) >>> 16;
            if (t > 32767) begin er = 16'h7FFF; nv = 1'b1; end
            else if (t < -32768) begin er = 16'h8000; nv = 1'b1; end
            else begin er = int'(t) & 16'hFFFF; nv = 1'b0; end
            nz = (er == 0); nn = er[15];
         end
         default: ;
      endcase
      et = ref_taken(cc);
      // R12: result and taken due in the same cycle
      check(tg, "result", int'(result), er);
      check((cc >= 7 || cc == 0) ? "R11" : "R10", "taken", int'(taken), int'(et));
      @(posedge clk);
      #2;
      mc = nc; mz = nz; mn = nn; mv = nv; macc = nacc;
      // R12: flags due one edge later
      check(tg, "flags", int'(flags), int'({mc, mz, mn, mv}));
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         err_cnt++;
         $display("FAIL R12 watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; opcode = 4'd0; opnd_a = '0; opnd_b = '0; cond_sel = 4'd0;
      mc = 0; mz = 0; mn = 0; mv = 0; macc = 0;
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12", "reset flags", int'(flags), 0);
      rst_n = 1'b1;
      step(15, 0, 0, 7);                 // R12 accumulator cleared: RND gives 0

      // R1 add-type corners
      step(1, 16'h7FFF, 16'h0001, 1);
      step(1, 16'hFFFF, 16'h0001, 3);
      step(2, 16'h0000, 16'h0001, 1);
      step(2, 16'h0005, 16'h0005, 3);
      step(2, 16'h8000, 16'h0001, 6);
      step(4, 16'h7FFF, 0, 5);
      step(5, 16'h8000, 0, 2);
      step(5, 16'h0000, 0, 4);
      // R2 ABS
      step(3, 16'h8000, 0, 1);
      step(3, 16'hFFFB, 0, 1);
      step(3, 16'h0000, 0, 3);
      // R3 C survives logic ops
      step(1, 16'hFFFF, 16'h0002, 0);
      step(6, 16'hF0F0, 16'h0F0F, 3);
      step(7, 16'h8000, 16'h0001, 1);
      step(8, 16'h1234, 16'h1234, 3);
      step(9, 16'h0000, 0, 1);
      // R4 shifts use B[3:0]
      step(10, 16'h0001, 16'h0013, 6);
      step(10, 16'hFFFF, 16'h000F, 1);
      step(11, 16'h8000, 16'h0004, 4);
      step(11, 16'h8000, 16'hFFF0, 1);
      // R5/R8 products and rounding
      step(12, 16'h7FFF, 16'h7FFF, 0);
      step(15, 0, 0, 5);
      step(12, 16'h0001, 16'h4000, 0);
      step(15, 0, 0, 3);
      step(12, 16'h0002, 16'h4000, 0);
      step(15, 0, 0, 3);
      step(12, 16'h8000, 16'h0001, 1);
      step(15, 0, 0, 3);
      // R9 NOP leaves acc and flags
      step(0, 16'hFFFF, 16'hFFFF, 1);
      step(15, 0, 0, 2);
      // R6 MAC to overflow; R8 clamping
      step(12, 16'h8000, 16'h8000, 0);
      for (int k = 0; k < 511; k++) step(13, 16'h8000, 16'h8000, k % 16);
      step(15, 0, 0, 1);
      step(12, 16'h8000, 16'h8000, 0);
      for (int k = 0; k < 40; k++) step(13, 16'h7FFF, 16'h7FFF, 5);
      step(15, 0, 0, 5);
      // R7 clear
      step(14, 16'h1111, 16'h2222, 3);
      step(15, 0, 0, 3);
      // R10/R11 all condition codes over several flag states
      for (int k = 0; k < 16; k++) step(0, 0, 0, k);
      step(2, 16'h0001, 16'h0002, 0);
      for (int k = 0; k < 16; k++) step(0, 0, 0, k);
      step(2, 16'h0003, 16'h0002, 0);
      for (int k = 0; k < 16; k++) step(0, 0, 0, k);
      // mixed random traffic
      for (int k = 0; k < 3000; k++) begin
         int ra, rb;
         ra = (($urandom % 4) == 0) ? ((($urandom % 2) == 0) ? 16'h8000 : 16'h7FFF)
                                    : int'($urandom & 16'hFFFF);
         rb = (($urandom % 5) == 0) ? 16'hFFFF : int'($urandom & 16'hFFFF);
         step(int'($urandom % 16), ra, rb, int'($urandom % 16));
      end
      done = 1'b1;
      summary();
      $finish;
   end

endmodule